// File: doc/BRIEF.md
# Processor Control Register File

This block holds the three system control registers of a processor core: a mode-control register, a fault-address register and a page-directory-base register. Privileged software reads and writes them through a simple select/write port. Three hardware events also act on them: a task-switch event, a command that clears the task-switched flag, and a page-fault event that carries the faulting linear address.

From the mode-control register the block drives three level outputs: protected-mode enable, paging enable and task-switched. It also hands the page-directory base address to the paging unit. That base address is always aligned to a 4 KB page, so its low 12 bits are never stored and always read as zero. The fault-address register can only be loaded by hardware. Software writes aimed at it are dropped.

All registers are 32 bits wide. Register select codes are 0 for mode control, 1 for fault address, 2 for directory base, and 3 for an unmapped slot.

Top module: `ctrl_reg_file`

## Requirements
- R1: While rst_ni is low, every register is zero. So rd_data_o is zero for every select code, and prot_en_o, paging_en_o and task_switched_o are low. This is real mode with paging off.
- R2: A write with reg_sel_i = 0 stores all 32 bits of wr_data_i in the mode register at the next clock edge. prot_en_o follows bit 0 and paging_en_o follows bit 31.
- R3: A task_switch_i pulse sets mode bit 3 at the next edge. This overrides a same-cycle ts_clear_i and a same-cycle software write of bit 3.
- R4: ts_clear_i without task_switch_i clears mode bit 3 at the next edge. This overrides a same-cycle software write of bit 3.
- R5: page_fault_i loads fault_addr_i into the fault-address register (select 1) at the next edge.
- R6: A software write with reg_sel_i = 1 leaves the fault-address register unchanged.
- R7: A write with reg_sel_i = 2 stores wr_data_i bits 31..12. Bits 11..0 of the directory register read as zero. dir_base_o always equals the directory register value.
- R8: rd_data_o combinationally returns the register chosen by reg_sel_i. Select 3 reads zero, and writes to select 3 change no register.
- R9: task_switched_o follows mode bit 3. The bit holds its value in any cycle without a task switch, a clear command or a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Software register write strobe |
| reg_sel_i | input | 2 | Register select: 0 mode, 1 fault address, 2 directory base, 3 unmapped |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Read data for the selected register |
| task_switch_i | input | 1 | Task-switch event, sets the task-switched flag |
| ts_clear_i | input | 1 | Clear-task-switched command |
| page_fault_i | input | 1 | Page-fault event |
| fault_addr_i | input | 32 | Linear address that caused the fault |
| prot_en_o | output | 1 | Protected-mode enable (mode bit 0) |
| paging_en_o | output | 1 | Paging enable (mode bit 31) |
| task_switched_o | output | 1 | Task-switched flag (mode bit 3) |
| dir_base_o | output | 32 | Page-directory base address, 4 KB aligned |

## Verification
The assertions rely on one assumption about the inputs: every input is a clean, two-state value that is stable at each rising edge. Beyond that, they impose no mutual exclusion on the events. A task switch, a clear command, a page fault and a software write may all arrive together, and the priority checks depend on such overlaps happening. The random stimulus therefore draws each event independently each cycle, so collisions occur often. Directed cases force the two priority collisions explicitly, together with all-ones and alternating data patterns.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned PG_SHIFT   = 12;
  localparam int unsigned PROT_BIT   = 0;
  localparam int unsigned TS_BIT     = 3;
  localparam int unsigned PAGING_BIT = 31;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_FAULT = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mode_reg.sv
module mode_reg #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned TS_BIT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            ts_set_i,
  input  logic            ts_clr_i,
  output logic [XLEN-1:0] q_o
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    logic bit_q;
    if (b == TS_BIT) begin : g_ts
      // hw set beats clear command, both beat software
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (ts_set_i)  bit_q <= 1'b1;
        else if (ts_clr_i)  bit_q <= 1'b0;
        else if (wr_en_i)   bit_q <= wr_data_i[b];
      end
    end else begin : g_sw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (wr_en_i)  bit_q <= wr_data_i[b];
      end
    end
    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [XLEN-1:0] addr_i,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign q_o = addr_q;
endmodule

// File: rtl/dir_base_reg.sv
module dir_base_reg #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [XLEN-1:PG_SHIFT]   wr_hi_i,
  output logic [XLEN-1:0]          base_o
);
  localparam int unsigned HI_W = XLEN - PG_SHIFT;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (wr_en_i) hi_q <= wr_hi_i;
  end

  if (PG_SHIFT > 0) begin : g_aligned
    assign base_o = {hi_q, {PG_SHIFT{1'b0}}};
  end else begin : g_full
    assign base_o = hi_q;
  end
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
  import ctrl_reg_pkg::*;
#(
  parameter int unsigned DATA_W = ctrl_reg_pkg::XLEN,
  parameter int unsigned PG_SH  = ctrl_reg_pkg::PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              task_switch_i,
  input  logic              ts_clear_i,
  input  logic              page_fault_i,
  input  logic [DATA_W-1:0] fault_addr_i,
  output logic              prot_en_o,
  output logic              paging_en_o,
  output logic              task_switched_o,
  output logic [DATA_W-1:0] dir_base_o
);
  reg_sel_e sel;
  logic [DATA_W-1:0] mode_q, fault_q, dir_q;
  logic mode_we, dir_we;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign mode_we = wr_en_i && (sel == SEL_MODE);
  assign dir_we  = wr_en_i && (sel == SEL_DIR);

  mode_reg #(.XLEN(DATA_W), .TS_BIT(TS_BIT)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mode_we),
    .wr_data_i (wr_data_i),
    .ts_set_i  (task_switch_i),
    .ts_clr_i  (ts_clear_i),
    .q_o       (mode_q)
  );

  // software has no write path here
  fault_addr_reg #(.XLEN(DATA_W)) u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (page_fault_i),
    .addr_i (fault_addr_i),
    .q_o    (fault_q)
  );

  dir_base_reg #(.XLEN(DATA_W), .PG_SHIFT(PG_SH)) u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (dir_we),
    .wr_hi_i (wr_data_i[DATA_W-1:PG_SH]),
    .base_o  (dir_q)
  );

  always_comb begin
    unique case (sel)
      SEL_MODE:  rd_data_o = mode_q;
      SEL_FAULT: rd_data_o = fault_q;
      SEL_DIR:   rd_data_o = dir_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign prot_en_o       = mode_q[PROT_BIT];
  assign paging_en_o     = mode_q[PAGING_BIT];
  assign task_switched_o = mode_q[TS_BIT];
  assign dir_base_o      = dir_q;
endmodule

// File: rtl/ctrl_reg_file_chk.sv
module ctrl_reg_file_chk
  import ctrl_reg_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [1:0]      reg_sel_i,
  input logic [XLEN-1:0] wr_data_i,
  input logic [XLEN-1:0] rd_data_o,
  input logic            task_switch_i,
  input logic            ts_clear_i,
  input logic            page_fault_i,
  input logic [XLEN-1:0] fault_addr_i,
  input logic            prot_en_o,
  input logic            paging_en_o,
  input logic            task_switched_o,
  input logic [XLEN-1:0] dir_base_o,
  input logic [XLEN-1:0] fault_q
);
  logic mode_wr, dir_wr;
  assign mode_wr = wr_en_i && (reg_sel_i == 2'(SEL_MODE));
  assign dir_wr  = wr_en_i && (reg_sel_i == 2'(SEL_DIR));

  p_mode_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (prot_en_o == $past(wr_data_i[PROT_BIT]))
             && (paging_en_o == $past(wr_data_i[PAGING_BIT])));

  p_ts_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_switch_i |=> task_switched_o);

  p_ts_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_clear_i && !task_switch_i) |=> !task_switched_o);

  p_fault_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_i |=> (fault_q == $past(fault_addr_i)));

  p_fault_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_fault_i |=> $stable(fault_q));

  p_dir_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> (dir_base_o[XLEN-1:PG_SHIFT] == $past(wr_data_i[XLEN-1:PG_SHIFT]))
            && (dir_base_o[PG_SHIFT-1:0] == '0));

  p_dir_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr |=> $stable(dir_base_o));

  p_rd_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'(SEL_NONE)) |-> (rd_data_o == '0));

  p_rd_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'(SEL_FAULT)) |-> (rd_data_o == fault_q));

  p_ts_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!task_switch_i && !ts_clear_i && !mode_wr) |=> $stable(task_switched_o));
endmodule

bind ctrl_reg_file ctrl_reg_file_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .reg_sel_i       (reg_sel_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o),
  .task_switch_i   (task_switch_i),
  .ts_clear_i      (ts_clear_i),
  .page_fault_i    (page_fault_i),
  .fault_addr_i    (fault_addr_i),
  .prot_en_o       (prot_en_o),
  .paging_en_o     (paging_en_o),
  .task_switched_o (task_switched_o),
  .dir_base_o      (dir_base_o),
  .fault_q         (fault_q)
);

// File: tb/ctrl_reg_file_tb_top.sv
module ctrl_reg_file_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        task_switch_i = 1'b0;
  logic        ts_clear_i = 1'b0;
  logic        page_fault_i = 1'b0;
  logic [31:0] fault_addr_i = '0;
  logic        prot_en_o, paging_en_o, task_switched_o;
  logic [31:0] dir_base_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_mode = '0, m_fault = '0, m_dir = '0;

  always #5 clk_i = ~clk_i;

  ctrl_reg_file dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .reg_sel_i(reg_sel_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .task_switch_i(task_switch_i),
    .ts_clear_i(ts_clear_i), .page_fault_i(page_fault_i), .fault_addr_i(fault_addr_i),
    .prot_en_o(prot_en_o), .paging_en_o(paging_en_o), .task_switched_o(task_switched_o),
    .dir_base_o(dir_base_o)
  );

  function automatic logic [31:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0:    return m_mode;
      2'd1:    return m_fault;
      2'd2:    return m_dir;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model update from the requirements, applied for the inputs of one edge
  task automatic model_step();
    if (wr_en_i && reg_sel_i == 2'd0) m_mode = wr_data_i;
    if (ts_clear_i)    m_mode[3] = 1'b0;
    if (task_switch_i) m_mode[3] = 1'b1;
    if (page_fault_i)  m_fault = fault_addr_i;
    if (wr_en_i && reg_sel_i == 2'd2) m_dir = {wr_data_i[31:12], 12'h000};
  endtask

  task automatic check_outs(string req_rd);
    chk(req_rd, rd_data_o, exp_rd(reg_sel_i));
    chk("R2 prot_en", 32'(prot_en_o), 32'(m_mode[0]));
    chk("R2 paging_en", 32'(paging_en_o), 32'(m_mode[31]));
    chk("R9 task_switched", 32'(task_switched_o), 32'(m_mode[3]));
    chk("R7 dir_base", dir_base_o, m_dir);
  endtask

  task automatic cyc(bit we, logic [1:0] s, logic [31:0] wd, bit ts, bit clr,
                     bit pf, logic [31:0] fa, string req_rd);
    @(negedge clk_i);
    wr_en_i = we; reg_sel_i = s; wr_data_i = wd;
    task_switch_i = ts; ts_clear_i = clr; page_fault_i = pf; fault_addr_i = fa;
    @(posedge clk_i);
    model_step();
    #1;
    check_outs(req_rd);
  endtask

  task automatic idle_read(logic [1:0] s, string req);
    cyc(1'b0, s, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #2;
    for (int s = 0; s < 4; s++) begin
      reg_sel_i = 2'(s);
      #1;
      chk("R1 reset read", rd_data_o, 32'h0);
    end
    chk("R1 reset mode outs", {29'h0, prot_en_o, paging_en_o, task_switched_o}, 32'h0);
    chk("R1 reset dir_base", dir_base_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 all-ones and alternating patterns
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mode write ones");
    cyc(1'b1, 2'd0, 32'h5555_5555, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mode write 55");
    cyc(1'b1, 2'd0, 32'h8000_0001, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mode write ends");
    // R3 task switch beats clear and a write of bit 3 = 0
    cyc(1'b1, 2'd0, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, "R3 ts beats clear");
    chk("R3 ts flag set", 32'(task_switched_o), 32'h1);
    // R4 clear beats a write of bit 3 = 1
    cyc(1'b1, 2'd0, 32'h0000_0008, 1'b0, 1'b1, 1'b0, 32'h0, "R4 clear beats write");
    chk("R4 ts flag clear", 32'(task_switched_o), 32'h0);
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0, "R3 ts alone");
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0, "R4 clear alone");
    // R5 fault load, R6 software write ignored
    cyc(1'b0, 2'd1, 32'h0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, "R5 fault load");
    chk("R5 fault value", rd_data_o, 32'hDEAD_BEEF);
    cyc(1'b1, 2'd1, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h0, "R6 fault sw write");
    chk("R6 fault unchanged", rd_data_o, 32'hDEAD_BEEF);
    cyc(1'b1, 2'd1, 32'h0, 1'b0, 1'b0, 1'b1, 32'hFFFF_F001, "R5 fault with write");
    chk("R5 fault hw wins", rd_data_o, 32'hFFFF_F001);
    // R7 low bits forced to zero
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0, "R7 dir write ones");
    chk("R7 dir low zero", dir_base_o, 32'hFFFF_F000);
    // R8 unmapped select
    cyc(1'b1, 2'd3, 32'hA5A5_A5A5, 1'b0, 1'b0, 1'b0, 32'h0, "R8 unmapped write");
    chk("R8 unmapped read", rd_data_o, 32'h0);
    idle_read(2'd0, "R8 mode after unmapped write");
    idle_read(2'd1, "R8 fault after unmapped write");
    idle_read(2'd2, "R8 dir after unmapped write");

    for (int i = 0; i < 3000; i++) begin
      cyc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), $urandom(),
          ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 7) == 0), $urandom(), "R8 random read");
    end

    // R1 async reset mid-run
    @(negedge clk_i);
    wr_en_i = 1'b0; task_switch_i = 1'b0; ts_clear_i = 1'b0; page_fault_i = 1'b0;
    rst_ni = 1'b0;
    m_mode = '0; m_fault = '0; m_dir = '0;
    #1;
    for (int s = 0; s < 4; s++) begin
      reg_sel_i = 2'(s);
      #1;
      chk("R1 second reset read", rd_data_o, 32'h0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule